// File: doc/BRIEF.md
# Serial Control-Word Loader for a Dual-Modulus Frequency Synthesizer

This block takes configuration words for a frequency synthesizer from a host over a three-wire serial link made of a bit clock, a data line and a load strobe. All three lines and the power-save request are resynchronized into the system clock domain. Data bits are sampled on rising edges of the bit clock and enter a shift register MSB first. A rising edge on the strobe then hands the shifted word to one of two holding registers. Which register receives it depends on the last bit shifted in and on how many bits arrived since the previous strobe.

The reference register holds a prescaler modulus-select bit and a 14-bit reference divide ratio. The program register holds an 11-bit main count and a 7-bit swallow count. A host normally initializes the block by sending a reference word and then a program word. After that it retunes by sending only program words. Each register has its own valid flag. A strobe that does not complete a well-formed word loads nothing and raises an error flag. While power-save is active, the serial inputs have no effect and both registers keep their contents.

Top module: `synth_word_loader`

## Requirements
- R1: After reset, every register field, both valid flags and the error flag are 0.
- R2: Each synchronized rising edge of `ser_clk` shifts the value of `ser_data` into the word. The first bit sent is the most significant bit.
- R3: A strobe that follows exactly 16 bits whose final bit is 1 loads the reference register. In that word, bit 15 (sent first) goes to `ref_mod_sel`, bits 14..1 go to `ref_ratio` MSB first, and bit 0 is the flag. The strobe also sets `ref_valid`.
- R4: A strobe that follows exactly 19 bits whose final bit is 0 loads the program register. In that word, bits 18..8 go to `prog_main` MSB first, bits 7..1 go to `prog_swallow` MSB first, and bit 0 is the flag. The strobe also sets `prog_valid`.
- R5: Loading one register leaves the other register unchanged.
- R6: A strobe that follows a bit count other than 16 or 19, or whose final bit does not match the word length, loads nothing and sets `frame_err` to 1. The next accepted strobe clears `frame_err`.
- R7: Every strobe outside power-save restarts the bit count at zero. A word of 20 or more bits stays invalid even when its last 19 bits form a valid program word.
- R8: While `sleep` is 1, bit-clock edges and strobes are ignored. Both registers, the partial bit count and `frame_err` keep their values.
- R9: Once set, a valid flag stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_data | input | 1 | Serial data, sampled on ser_clk rising edges |
| ser_strobe | input | 1 | Load strobe, acts on its rising edge |
| sleep | input | 1 | Power-save request, active high |
| ref_mod_sel | output | 1 | Prescaler modulus-select bit |
| ref_ratio | output | 14 | Reference divide ratio |
| ref_valid | output | 1 | Reference register has been loaded |
| prog_main | output | 11 | Main counter value |
| prog_swallow | output | 7 | Swallow counter value |
| prog_valid | output | 1 | Program register has been loaded |
| frame_err | output | 1 | Last strobe carried a malformed word |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 14-bit reference ratio, an 11-bit main count and a 7-bit swallow count. These give the 16-bit and 19-bit word lengths that the requirements state. With these values the bench can drive all-ones and all-zero fields, words with the wrong flag for their length, short words, and an overlong word whose tail looks valid. It can also split one word across a power-save interval, so the bench checks both the routing of each bit and the saturating bit count.

// File: rtl/synth_word_loader.sv
module synth_word_loader #(
  parameter int SYNC_STAGES = 2,
  parameter int RATIO_W     = 14,
  parameter int MAIN_W      = 11,
  parameter int SWALLOW_W   = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_data,
  input  logic                 ser_strobe,
  input  logic                 sleep,
  output logic                 ref_mod_sel,
  output logic [RATIO_W-1:0]   ref_ratio,
  output logic                 ref_valid,
  output logic [MAIN_W-1:0]    prog_main,
  output logic [SWALLOW_W-1:0] prog_swallow,
  output logic                 prog_valid,
  output logic                 frame_err
);
  localparam int REF_LEN  = RATIO_W + 2;
  localparam int PROG_LEN = MAIN_W + SWALLOW_W + 1;
  localparam int SH_W     = (REF_LEN > PROG_LEN) ? REF_LEN : PROG_LEN;
  localparam int CNT_MAX  = SH_W + 1;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  logic [SYNC_STAGES:0]   ck_q, st_q;
  logic [SYNC_STAGES-1:0] dt_q, sl_q;
  logic [SH_W-1:0]        shreg;
  logic [CNT_W-1:0]       bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0;
      st_q <= '0;
      dt_q <= '0;
      sl_q <= '0;
    end else begin
      ck_q <= {ck_q[SYNC_STAGES-1:0], ser_clk};
      st_q <= {st_q[SYNC_STAGES-1:0], ser_strobe};
      dt_q <= {dt_q[SYNC_STAGES-2:0], ser_data};
      sl_q <= {sl_q[SYNC_STAGES-2:0], sleep};
    end
  end

  wire sleep_s  = sl_q[SYNC_STAGES-1];
  wire data_s   = dt_q[SYNC_STAGES-1];
  wire clk_rise = ck_q[SYNC_STAGES-1] & ~ck_q[SYNC_STAGES] & ~sleep_s;
  wire stb_rise = st_q[SYNC_STAGES-1] & ~st_q[SYNC_STAGES] & ~sleep_s;

  wire ref_ok  = (bit_cnt == CNT_W'(REF_LEN))  &  shreg[0];
  wire prog_ok = (bit_cnt == CNT_W'(PROG_LEN)) & ~shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (stb_rise) begin
      bit_cnt <= '0;
    end else if (clk_rise) begin
      shreg <= {shreg[SH_W-2:0], data_s};
      if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_mod_sel  <= 1'b0;
      ref_ratio    <= '0;
      ref_valid    <= 1'b0;
      prog_main    <= '0;
      prog_swallow <= '0;
      prog_valid   <= 1'b0;
      frame_err    <= 1'b0;
    end else if (stb_rise) begin
      frame_err <= ~(ref_ok | prog_ok);
      if (ref_ok) begin
        ref_mod_sel <= shreg[REF_LEN-1];
        ref_ratio   <= shreg[REF_LEN-2:1];
        ref_valid   <= 1'b1;
      end
      if (prog_ok) begin
        prog_main    <= shreg[PROG_LEN-1 -: MAIN_W];
        prog_swallow <= shreg[SWALLOW_W:1];
        prog_valid   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_word_loader_chk.sv
module synth_word_loader_chk #(
  parameter int RATIO_W   = 14,
  parameter int MAIN_W    = 11,
  parameter int SWALLOW_W = 7,
  parameter int CNT_W     = 5,
  parameter int CNT_MAX   = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sleep_s,
  input logic                 ref_mod_sel,
  input logic [RATIO_W-1:0]   ref_ratio,
  input logic                 ref_valid,
  input logic [MAIN_W-1:0]    prog_main,
  input logic [SWALLOW_W-1:0] prog_swallow,
  input logic                 prog_valid,
  input logic                 frame_err,
  input logic [CNT_W-1:0]     bit_cnt
);
  AST_REF_CHANGE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ref_mod_sel, ref_ratio}) |-> ref_valid); // R3
  AST_PROG_CHANGE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({prog_main, prog_swallow}) |-> prog_valid); // R4
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable({ref_mod_sel, ref_ratio}) && !$stable({prog_main, prog_swallow}))); // R5
  AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $stable({ref_mod_sel, ref_ratio, prog_main, prog_swallow})); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(CNT_MAX)); // R7
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_s |=> $stable({ref_mod_sel, ref_ratio, prog_main, prog_swallow, frame_err, bit_cnt})); // R8
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid |=> ref_valid) and (prog_valid |=> prog_valid)); // R9
endmodule

bind synth_word_loader synth_word_loader_chk #(
  .RATIO_W(RATIO_W), .MAIN_W(MAIN_W), .SWALLOW_W(SWALLOW_W),
  .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_s(sleep_s),
  .ref_mod_sel(ref_mod_sel), .ref_ratio(ref_ratio), .ref_valid(ref_valid),
  .prog_main(prog_main), .prog_swallow(prog_swallow), .prog_valid(prog_valid),
  .frame_err(frame_err), .bit_cnt(bit_cnt)
);

// File: tb/tb_synth_word_loader.sv
module tb_synth_word_loader;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_strobe = 0, sleep = 0;
  logic        ref_mod_sel, ref_valid, prog_valid, frame_err;
  logic [13:0] ref_ratio;
  logic [10:0] prog_main;
  logic [6:0]  prog_swallow;

  int checks = 0, errors = 0;
  logic        e_mod = 0, e_rv = 0, e_pv = 0, e_err = 0;
  logic [13:0] e_ratio = 0;
  logic [10:0] e_main = 0;
  logic [6:0]  e_sw = 0;

  always #10 clk = ~clk;

  synth_word_loader dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .sleep(sleep), .ref_mod_sel(ref_mod_sel),
    .ref_ratio(ref_ratio), .ref_valid(ref_valid), .prog_main(prog_main),
    .prog_swallow(prog_swallow), .prog_valid(prog_valid), .frame_err(frame_err)
  );

  localparam logic [23:0] VEC [8] = '{
    {5'd12, 7'd0, 12'hABC},
    {5'd16, 3'd0, 1'b1, 14'h1234, 1'b1},
    {5'd19, 11'h5A5, 7'h33, 1'b0},
    {5'd19, 11'h123, 7'h45, 1'b1},
    {5'd16, 3'd0, 1'b0, 14'h2AAA, 1'b0},
    {5'd16, 3'd0, 1'b0, 14'h3FFF, 1'b1},
    {5'd19, 11'h7FF, 7'h7F, 1'b0},
    {5'd19, 11'h000, 7'h00, 1'b0}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_data = b; wait_clk(6);
    ser_clk = 1;  wait_clk(6);
    ser_clk = 0;  wait_clk(6);
  endtask

  task automatic send_bits(input logic [18:0] w, input int len);
    for (int i = len - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic strobe();
    ser_strobe = 1; wait_clk(6);
    ser_strobe = 0; wait_clk(8);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "ref", {ref_valid, ref_mod_sel, ref_ratio}, {e_rv, e_mod, e_ratio});
    chk(req, "prog", {prog_valid, prog_main, prog_swallow}, {e_pv, e_main, e_sw});
    chk(req, "err", frame_err, e_err);
  endtask

  task automatic model(input logic [18:0] w, input int len);
    if (len == 16 && w[0]) begin
      e_mod = w[15]; e_ratio = w[14:1]; e_rv = 1; e_err = 0;
    end else if (len == 19 && !w[0]) begin
      e_main = w[18:8]; e_sw = w[7:1]; e_pv = 1; e_err = 0;
    end else e_err = 1;
  endtask

  initial begin
    int guard = 0;
    while (guard < 150000) begin @(posedge clk); guard++; end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(4);
    check_all("R1 reset");
    rst_n = 1; wait_clk(4);
    check_all("R1 after release");

    for (int v = 0; v < 8; v++) begin
      send_bits(VEC[v][18:0], int'(VEC[v][23:19]));
      strobe();
      model(VEC[v][18:0], int'(VEC[v][23:19]));
      check_all(v == 0 ? "R6 short word" : v == 3 || v == 4 ? "R6 flag mismatch" :
                v == 1 || v == 5 ? "R3 R5 ref load" : "R2 R4 R5 prog load");
    end
    chk("R9 valid held", "valids", {ref_valid, prog_valid}, 2'b11);

    send_bits(19'h0, 3);
    send_bits({11'h4C1, 7'h2D, 1'b0}, 19);
    strobe();
    e_err = 1;
    check_all("R7 overlong word");

    send_bits({11'h0F0, 7'h0F, 1'b0}, 19);
    strobe();
    model({11'h0F0, 7'h0F, 1'b0}, 19);
    check_all("R7 count restart");

    send_bits({11'h6A6, 7'h19, 1'b0}, 10);
    sleep = 1; wait_clk(6);
    send_bits({11'h6A6, 7'h19, 1'b0}, 9);
    strobe();
    check_all("R8 sleep ignores strobe");
    sleep = 0; wait_clk(6);
    strobe();
    e_err = 1;
    check_all("R8 partial count kept");

    send_bits({11'h6A6, 7'h19, 1'b0}, 19);
    strobe();
    model({11'h6A6, 7'h19, 1'b0}, 19);
    check_all("R4 retune after wake");

    rst_n = 0; wait_clk(3);
    e_mod = 0; e_ratio = 0; e_rv = 0; e_main = 0; e_sw = 0; e_pv = 0; e_err = 0;
    check_all("R1 reset again");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule